// File: doc/BRIEF.md
# Dual-Personality Parallel Host Bus Slave

This block is the register-access front end of a peripheral. A host processor reaches a bank of 32 byte-wide registers through one of four parallel bus personalities. It can use separate read and write strobes with a ready line, or a single data strobe with a direction line and an active-low acknowledge. Each of the two strobe styles can carry its address on a dedicated 5-bit address bus, or time-share it with the data byte on the data lines behind an address-latch-enable pulse. A static two-bit mode input selects the personality.

Every host-side control, address and data input first passes through a two-stage synchronizer clocked by the system clock. A single state machine then finds strobe edges synchronously. Its states are IDLE (no access), WAIT (handshake held off for a fixed number of clocks) and DONE (handshake granted until the strobe is released). The transitions are: IDLE to WAIT when a selected strobe asserts; WAIT to DONE when the wait count runs out; WAIT or DONE back to IDLE when the strobe is released. Write data is committed on that release edge.

The data bus is split into input, output and output-enable, so that the pad tristate can sit in the chip's I/O ring.

Top module: `hostbus_slave`

## Requirements
- R1: After reset every register reads 0x00, `rdy` is high, `ack_n` is high and `bus_oe` is low.
- R2: With `bus_mode[1]`=0, a write access (`wr_n` low with `cs_n` low) stores the byte present on `bus_i` when `wr_n` rises.
- R3: With `bus_mode[1]`=0, a read access (`rd_n` low with `cs_n` low) drives the addressed register on `bus_o` with `bus_oe` high.
- R4: With `bus_mode[1]`=0, `rdy` goes low for exactly WAIT_CYC (default 2) clocks after the strobe is seen, then returns high, and is never low for more than WAIT_CYC consecutive clocks.
- R5: With `bus_mode[1]`=1, `ds_n` low with `rw`=0 stores the byte on `bus_i` at the rising edge of `ds_n`, and `ds_n` low with `rw`=1 drives the addressed register on `bus_o`.
- R6: With `bus_mode[1]`=1, `ack_n` goes low once the wait period ends and stays low until `ds_n` is released. `ack_n` is never low when `bus_mode[1]`=0, and `rdy` is never low when `bus_mode[1]`=1.
- R7: With `bus_mode[0]`=0, the address is taken from `addr_i` when the strobe asserts, and later changes on `addr_i` during the same access have no effect.
- R8: With `bus_mode[0]`=1, the address is taken from `bus_i[4:0]` at the falling edge of `ale`, and `addr_i` is ignored.
- R9: While `cs_n` is high, strobes cause no write, no `bus_oe` and no handshake.
- R10: The `bus_mode` encoding is bit 1 = data-strobe style (0 = separate read/write strobes) and bit 0 = multiplexed address/data (0 = separate address bus).
- R11: `bus_oe` is high only during a selected read strobe, and it stays low throughout every write access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_mode | input | 2 | Static personality select (see R10) |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low (separate-strobe style) |
| wr_n | input | 1 | Write strobe, active low (separate-strobe style) |
| ds_n | input | 1 | Data strobe, active low (data-strobe style) |
| rw | input | 1 | Direction, 1 = read, 0 = write (data-strobe style) |
| ale | input | 1 | Address latch enable, address taken on its falling edge (multiplexed) |
| addr_i | input | 5 | Register address (non-multiplexed) |
| bus_i | input | 8 | Data, or address then data, from the host |
| bus_o | output | 8 | Read data towards the host |
| bus_oe | output | 1 | Output enable for the data pad tristate |
| rdy | output | 1 | Ready, low inserts wait states (separate-strobe style) |
| ack_n | output | 1 | Acknowledge, active low (data-strobe style) |

## Verification
The bench writes in one personality and reads back in another. A design that decoded either mode bit the wrong way, or latched the address from the wrong source, returns the wrong byte. During non-multiplexed accesses it changes the address pins after the handshake, and during multiplexed accesses it drives the inverted address on them, so that an address sampled late or from the wrong bus lands in the wrong register. It counts the ready-low clocks exactly and watches for a handshake that appears in the wrong personality. It also makes a deselected access and checks that nothing was written, driven or handshaken.

// File: rtl/hb_pkg.sv
package hb_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_DONE = 2'd2
    } hb_state_e;

    localparam int MODE_DSTROBE_BIT = 1;
    localparam int MODE_MUXED_BIT   = 0;
endpackage

// File: rtl/hb_sync.sv
module hb_sync #(
    parameter int             W   = 1,
    parameter logic [W-1:0]   RST = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1 <= RST;
            q      <= RST;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/hb_regfile.sv
module hb_regfile #(
    parameter int AW = 5,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_reg
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    mem[g] <= '0;
                else if (we && (addr == AW'(g)))
                    mem[g] <= wdata;
            end
        end
    endgenerate

    assign rdata = mem[addr];
endmodule

// File: rtl/hb_fsm.sv
module hb_fsm
    import hb_pkg::*;
#(
    parameter int AW       = 5,
    parameter int DW       = 8,
    parameter int WAIT_CYC = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          dstrobe_mode,
    input  logic          muxed_mode,
    input  logic          cs_s_n,
    input  logic          rd_s_n,
    input  logic          wr_s_n,
    input  logic          ds_s_n,
    input  logic          rw_s,
    input  logic          ale_s,
    input  logic [AW-1:0] addr_s,
    input  logic [DW-1:0] bus_s,
    output logic          we,
    output logic [AW-1:0] addr_q,
    output logic          rdy,
    output logic          ack_n,
    output logic          oe
);
    localparam int CW = $clog2(WAIT_CYC + 1);
    localparam logic [CW-1:0] CNT_LAST = CW'(WAIT_CYC - 1);

    hb_state_e     state, state_nx;
    logic [CW-1:0] cnt;
    logic          read_q;
    logic          ale_d;
    logic          strb;
    logic          rd_now;

    assign strb   = !cs_s_n && (dstrobe_mode ? !ds_s_n : (!rd_s_n || !wr_s_n));
    assign rd_now = dstrobe_mode ? rw_s : !rd_s_n;

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (strb) state_nx = ST_WAIT;
            ST_WAIT: begin
                if (!strb)                 state_nx = ST_IDLE;
                else if (cnt == CNT_LAST)  state_nx = ST_DONE;
            end
            ST_DONE: if (!strb) state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    // state register plus per-access bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            cnt    <= '0;
            read_q <= 1'b0;
            addr_q <= '0;
            ale_d  <= 1'b0;
        end else begin
            state <= state_nx;
            ale_d <= ale_s;
            if (state == ST_IDLE && strb) begin
                cnt    <= '0;
                read_q <= rd_now;
                if (!muxed_mode)
                    addr_q <= addr_s;
            end else if (state == ST_WAIT) begin
                cnt <= cnt + 1'b1;
            end
            if (muxed_mode && ale_d && !ale_s)
                addr_q <= bus_s[AW-1:0];
        end
    end

    // outputs decoded from state
    always_comb begin
        rdy   = 1'b1;
        ack_n = 1'b1;
        oe    = 1'b0;
        we    = 1'b0;
        unique case (state)
            ST_IDLE: ;
            ST_WAIT: begin
                rdy = dstrobe_mode;
                oe  = read_q && strb;
                we  = !read_q && !strb;
            end
            ST_DONE: begin
                ack_n = !dstrobe_mode;
                oe    = read_q && strb;
                we    = !read_q && !strb;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/hostbus_slave.sv
module hostbus_slave
    import hb_pkg::*;
#(
    parameter int AW       = 5,
    parameter int DW       = 8,
    parameter int WAIT_CYC = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    bus_mode,
    input  logic          cs_n,
    input  logic          rd_n,
    input  logic          wr_n,
    input  logic          ds_n,
    input  logic          rw,
    input  logic          ale,
    input  logic [AW-1:0] addr_i,
    input  logic [DW-1:0] bus_i,
    output logic [DW-1:0] bus_o,
    output logic          bus_oe,
    output logic          rdy,
    output logic          ack_n
);
    localparam int NCTL = 6;
    localparam logic [NCTL-1:0] CTL_RST = 6'b111110;

    logic [NCTL-1:0] ctl_s;
    logic [AW-1:0]   addr_s;
    logic [DW-1:0]   bus_s;
    logic            we;
    logic [AW-1:0]   addr_q;

    hb_sync #(.W(NCTL), .RST(CTL_RST)) u_ctl_sync (
        .clk(clk), .rst_n(rst_n),
        .d({cs_n, rd_n, wr_n, ds_n, rw, ale}), .q(ctl_s)
    );

    hb_sync #(.W(AW), .RST('0)) u_addr_sync (
        .clk(clk), .rst_n(rst_n), .d(addr_i), .q(addr_s)
    );

    hb_sync #(.W(DW), .RST('0)) u_bus_sync (
        .clk(clk), .rst_n(rst_n), .d(bus_i), .q(bus_s)
    );

    hb_fsm #(.AW(AW), .DW(DW), .WAIT_CYC(WAIT_CYC)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .dstrobe_mode(bus_mode[MODE_DSTROBE_BIT]),
        .muxed_mode(bus_mode[MODE_MUXED_BIT]),
        .cs_s_n(ctl_s[5]), .rd_s_n(ctl_s[4]), .wr_s_n(ctl_s[3]),
        .ds_s_n(ctl_s[2]), .rw_s(ctl_s[1]), .ale_s(ctl_s[0]),
        .addr_s(addr_s), .bus_s(bus_s),
        .we(we), .addr_q(addr_q),
        .rdy(rdy), .ack_n(ack_n), .oe(bus_oe)
    );

    hb_regfile #(.AW(AW), .DW(DW)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(we), .addr(addr_q),
        .wdata(bus_s), .rdata(bus_o)
    );
endmodule

// File: rtl/hb_chk.sv
module hb_chk #(
    parameter int WAIT_CYC = 2
) (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] bus_mode,
    input logic       cs_n,
    input logic       rdy,
    input logic       ack_n,
    input logic       bus_oe
);
    logic [7:0] low_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    low_run <= '0;
        else if (!rdy) low_run <= low_run + 1'b1;
        else           low_run <= '0;
    end

    // R6
    rdy_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rdy |-> !bus_mode[1]);

    // R6
    ack_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_n |-> bus_mode[1]);

    // R4
    rdy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rdy |-> (low_run < 8'(WAIT_CYC)));

    // R3
    oe_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(bus_oe) && !bus_mode[1]) |-> !rdy);

    // R9
    desel_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n && $past(cs_n) && $past(cs_n, 2) && $past(cs_n, 3))
            |-> (!bus_oe && rdy && ack_n));
endmodule

bind hostbus_slave hb_chk #(.WAIT_CYC(WAIT_CYC)) chk_i (
    .clk(clk), .rst_n(rst_n), .bus_mode(bus_mode), .cs_n(cs_n),
    .rdy(rdy), .ack_n(ack_n), .bus_oe(bus_oe)
);

// File: tb/hostbus_slave_tb_top.sv
module hostbus_slave_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bus_mode = 2'b00;
    logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, ds_n = 1'b1, rw = 1'b1, ale = 1'b0;
    logic [4:0] addr_i = '0;
    logic [7:0] bus_i = '0;
    logic [7:0] bus_o;
    logic       bus_oe, rdy, ack_n;

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] model [32];

    always #4 clk = ~clk;

    hostbus_slave dut_i (
        .clk(clk), .rst_n(rst_n), .bus_mode(bus_mode), .cs_n(cs_n),
        .rd_n(rd_n), .wr_n(wr_n), .ds_n(ds_n), .rw(rw), .ale(ale),
        .addr_i(addr_i), .bus_i(bus_i), .bus_o(bus_o), .bus_oe(bus_oe),
        .rdy(rdy), .ack_n(ack_n)
    );

    // {mode[1:0], write, addr[4:0], data[7:0]}
    localparam int NV = 13;
    localparam logic [15:0] VEC [NV] = '{
        {2'd0, 1'b1, 5'h03, 8'hA5},
        {2'd1, 1'b1, 5'h1F, 8'h3C},
        {2'd2, 1'b1, 5'h00, 8'h81},
        {2'd3, 1'b1, 5'h10, 8'h7E},
        {2'd0, 1'b0, 5'h1F, 8'h00},
        {2'd1, 1'b0, 5'h00, 8'h00},
        {2'd2, 1'b0, 5'h10, 8'h00},
        {2'd3, 1'b0, 5'h03, 8'h00},
        {2'd2, 1'b1, 5'h1F, 8'hC3},
        {2'd1, 1'b0, 5'h1F, 8'h00},
        {2'd0, 1'b0, 5'h05, 8'h00},
        {2'd3, 1'b1, 5'h05, 8'hFF},
        {2'd2, 1'b0, 5'h05, 8'h00}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_access(input logic [1:0] mode, input bit wr, input logic [4:0] a,
                             input logic [7:0] d, input bit sel,
                             output logic [7:0] rval, output int lows, output bit done,
                             output bit oe_bad, output bit hs_bad);
        lows = 0; done = 1'b0; oe_bad = 1'b0; hs_bad = 1'b0; rval = 8'h00;
        @(negedge clk);
        bus_mode = mode;
        if (mode[0]) begin
            addr_i = ~a;
            bus_i  = {3'b000, a};
            ale    = 1'b1;
            repeat (3) @(negedge clk);
            ale    = 1'b0;
            repeat (3) @(negedge clk);
        end else begin
            addr_i = a;
        end
        bus_i = wr ? d : 8'h00;
        cs_n  = !sel;
        if (mode[1]) begin
            rw = !wr; ds_n = 1'b0;
        end else if (wr) begin
            wr_n = 1'b0;
        end else begin
            rd_n = 1'b0;
        end
        for (int k = 0; k < 16 && !done; k++) begin
            @(negedge clk);
            if (!rdy) lows++;
            if (bus_oe && (wr || !sel)) oe_bad = 1'b1;
            if ((!rdy && mode[1]) || (!ack_n && !mode[1])) hs_bad = 1'b1;
            if ((!mode[1] && lows > 0 && rdy) || (mode[1] && !ack_n)) begin
                done = 1'b1;
                rval = bus_oe ? bus_o : 8'hEE;
            end
        end
        if (!mode[0]) addr_i = ~a;
        @(negedge clk);
        rd_n = 1'b1; wr_n = 1'b1; ds_n = 1'b1;
        repeat (3) @(negedge clk);
        cs_n = 1'b1; rw = 1'b1; bus_i = 8'h00;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        logic [7:0] rv;
        int         lw;
        bit         dn, ob, hb;
        for (int i = 0; i < 32; i++) model[i] = 8'h00;
        repeat (3) @(negedge clk);
        // R1 reset state of handshake and bus enable
        check(rdy === 1'b1 && ack_n === 1'b1 && bus_oe === 1'b0, "R1 outputs in reset",
              {rdy, ack_n, bus_oe}, 3'b110);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        // R1 register contents after reset
        do_access(2'd0, 1'b0, 5'h0A, 8'h00, 1'b1, rv, lw, dn, ob, hb);
        check(dn && rv == 8'h00, "R1 reset register value", rv, 0);

        for (int v = 0; v < NV; v++) begin
            logic [1:0] m; logic w; logic [4:0] a; logic [7:0] d;
            {m, w, a, d} = VEC[v];
            do_access(m, w, a, d, 1'b1, rv, lw, dn, ob, hb);
            if (!m[1])
                check(dn && lw == 2, "R4 ready wait count", lw, 2);
            else
                check(dn && lw == 0, "R6 acknowledge seen", lw, 0);
            check(!hb, "R6 handshake in wrong mode (R10)", hb, 0);
            check(!ob, "R11 output enable outside read", ob, 0);
            if (w) begin
                model[a] = d;   // R2 R5 write at strobe release
            end else begin
                check(rv == model[a], m[0] ? "R8 muxed read data (R3 R5)" : "R7 read data (R3 R5)",
                      rv, model[a]);
            end
        end

        // R9 deselected write: no handshake, no enable, no storage
        do_access(2'd0, 1'b1, 5'h03, 8'h11, 1'b0, rv, lw, dn, ob, hb);
        check(!dn && lw == 0 && !ob, "R9 deselected access quiet", lw, 0);
        do_access(2'd2, 1'b0, 5'h03, 8'h00, 1'b1, rv, lw, dn, ob, hb);
        check(rv == 8'hA5, "R9 deselected write ignored", rv, 8'hA5);

        // R2 write then immediate read-back with same strobe style
        do_access(2'd0, 1'b1, 5'h0B, 8'h5A, 1'b1, rv, lw, dn, ob, hb);
        do_access(2'd0, 1'b0, 5'h0B, 8'h00, 1'b1, rv, lw, dn, ob, hb);
        check(rv == 8'h5A, "R2 write captured at strobe rise", rv, 8'h5A);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule